// File: doc/BRIEF.md
# Error-Diffusion Grayscale Quantizer

This block turns a stream of 24-bit grayscale pixels into 8-bit codes for a narrow display converter. It does not just drop the low 16 bits. It rounds each pixel to the nearest output code and keeps the rounding remainder as a signed error. That error is added to pixels not yet processed, so a smooth gradient comes out as a fine dither rather than as visible bands.

The block takes one pixel per clock. Each pixel carries a start-of-line flag and a start-of-frame flag. Every line holds exactly `LINE_W` pixels, and the first pixel of each line carries the start-of-line flag. The first pixel of a frame carries the start-of-frame flag and also counts as a line start.

A mode input is sampled with each pixel and selects how the error is spread:
- Row mode keeps all of the error on the current line.
- Area mode also passes part of the error to the line below, through a buffer that holds one line of error sums.

Output codes appear after a fixed two-cycle latency.

Top module: `errdif_quantizer`

## Requirements
- R1: A pixel accepted with `in_valid`=1 at clock edge n shows up with `out_valid`=1 after edge n+2. `out_valid` is never high without a matching input, and idle gaps are allowed between pixels.
- R2: The output code follows from the corrected value `c`, where `c = clamp(pixel + incoming_error, 0, 2^24-1)`. The code is `min(255, floor((c + 2^15) / 2^16))`, which is round-to-nearest with ties rounding up and saturation at 255.
- R3: The error of a pixel is `e = c - code*2^16`, taken from the clamped value. It always lies in [-2^15, 2^16-1].
- R4: Row mode (`diff_mode`=0): the incoming error of a pixel is the full error `e` of the previous pixel on the same line. Line-buffer contents are not added.
- R5: Area mode (`diff_mode`=1): pixel x of line y passes errors onward as follows. Each share is an arithmetic right shift by 4 applied separately to the product.
  - `floor(7e/16)` to pixel x+1 of line y.
  - `floor(3e/16)` to pixel x-1 of line y+1.
  - `floor(5e/16)` to pixel x of line y+1.
  - `floor(e/16)` to pixel x+1 of line y+1.

  In area mode the incoming error is the horizontal share plus the sum stored for that column.
- R6: The first pixel of every line receives no horizontal error.
- R7: The first line of a frame (the line starting with `in_sof`=1) receives no vertical error, whatever the previous frame left behind.
- R8: Shares aimed left of column 0 or right of column `LINE_W-1` are dropped.
- R9: While `rst_n`=0 at a clock edge, `out_valid` and `out_pix` become 0.
- R10: A row-mode pixel passes nothing to the line below. An area-mode line that follows a row-mode line therefore receives no vertical error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Pixel present this cycle |
| in_sof | input | 1 | First pixel of a frame (also a line start) |
| in_sol | input | 1 | First pixel of a line |
| in_pix | input | 24 | Grayscale input pixel |
| diff_mode | input | 1 | 0 = row diffusion, 1 = area diffusion |
| out_valid | output | 1 | Output code present |
| out_pix | output | 8 | Quantized 8-bit code |

## Verification
The final next-line sum of a line, for column `LINE_W-1`, is written one cycle late. It is written in the same cycle that the first pixel of the following line clears its horizontal error and reads column 0. The bench drives lines back to back with no idle cycle, so these two events always collide. It also drives a line with idle gaps so that the deferred write sits pending across idle cycles. Any mix-up shows as a wrong code at the last column one line later, which the behavioural model catches because it keeps its next-line sums in a separate array per line and checks every output clock.

// File: rtl/errdif_pkg.sv
// errdif_pkg: shared mode type and diffusion weights for the quantizer.
// Assumes weights are expressed in sixteenths (shift of 4).
package errdif_pkg;

    typedef enum logic {
        MODE_ROW  = 1'b0,
        MODE_AREA = 1'b1
    } diff_mode_e;

    localparam int W_RIGHT  = 7;
    localparam int W_DLEFT  = 3;
    localparam int W_DOWN   = 5;
    localparam int W_DRIGHT = 1;
    localparam int W_SHIFT  = 4;

endpackage

// File: rtl/errdif_linebuf.sv
// errdif_linebuf: one line of next-line error sums, one write and one
// registered read port. Assumes the caller never reads and writes the
// same address in one cycle; contents are not reset.
module errdif_linebuf #(
    parameter int DEPTH = 512,
    parameter int W     = 18,
    parameter int AW    = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data
);

    logic [W-1:0] mem [DEPTH];

    // Store one error sum per write
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Registered read, one cycle after the address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= mem[rd_addr];
        end
    end

endmodule

// File: rtl/errdif_quant.sv
// errdif_quant: adds the signed incoming error to a pixel, clamps to the
// input range, rounds to the nearest output code and reports the residue.
// Purely combinational; assumes |e_in| stays inside EW+1 signed bits.
module errdif_quant #(
    parameter int IN_W  = 24,
    parameter int OUT_W = 8,
    parameter int EW    = 18
) (
    input  logic [IN_W-1:0]        pix,
    input  logic signed [EW:0]     e_in,
    output logic [OUT_W-1:0]       code,
    output logic signed [EW-1:0]   err
);

    localparam int FRAC_W = IN_W - OUT_W;
    localparam int SW     = IN_W + 2;
    localparam logic signed [SW-1:0] TOP_V = $signed({2'b00, {IN_W{1'b1}}});

    logic signed [SW-1:0] sum;
    logic [IN_W-1:0]      clamped;
    logic [OUT_W:0]       up;
    logic signed [SW-1:0] diff;

    // Corrected value, clamped to the input range
    always_comb begin
        sum = $signed({2'b00, pix}) + SW'(e_in);
        if (sum < 0) begin
            clamped = '0;
        end else if (sum > TOP_V) begin
            clamped = '1;
        end else begin
            clamped = sum[IN_W-1:0];
        end
    end

    // Round half up on the top bits, saturating at the largest code
    always_comb begin
        up   = {1'b0, clamped[IN_W-1:FRAC_W]} + (OUT_W+1)'(clamped[FRAC_W-1]);
        code = up[OUT_W] ? '1 : up[OUT_W-1:0];
        diff = $signed({2'b00, clamped}) - $signed({2'b00, code, {FRAC_W{1'b0}}});
        err  = EW'(diff);
    end

endmodule

// File: rtl/errdif_spread.sv
// errdif_spread: holds the horizontal error and the running next-line sums,
// forms the incoming error for the current pixel and writes finished sums
// to the line buffer. The last column's sum is deferred to the first pixel
// of the next line. Assumes full lines of LINE_W pixels and col==0 exactly
// on line starts.
module errdif_spread
    import errdif_pkg::*;
#(
    parameter int EW     = 18,
    parameter int LINE_W = 512,
    parameter int AW     = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vld,
    input  logic               sol,
    input  logic               sof,
    input  diff_mode_e         mode,
    input  logic [AW-1:0]      col,
    input  logic signed [EW-1:0] err,
    input  logic [EW-1:0]      rd_data,
    output logic signed [EW:0] e_in,
    output logic               wr_en,
    output logic [AW-1:0]      wr_addr,
    output logic [EW-1:0]      wr_data
);

    localparam int PW = EW + 4;
    localparam logic [AW-1:0] LAST = AW'(LINE_W - 1);

    logic signed [EW-1:0] h_reg, pend0, pend1, flush_data;
    logic                 first_line, flush_pend;
    logic                 line_start, fl_eff, last_col, area;
    logic signed [EW-1:0] h_eff, v_eff, pend1_eff;
    logic signed [PW-1:0] ex, m7, m3, m5;
    logic signed [EW-1:0] c7, c3, c5, c1;
    logic                 pix_wr, flush_wr;

    // Line/frame context of the current pixel
    always_comb begin
        line_start = sol | sof;
        fl_eff     = sof ? 1'b1 : (sol ? 1'b0 : first_line);
        last_col   = (col == LAST);
        area       = (mode == MODE_AREA);
        h_eff      = line_start ? '0 : h_reg;
        v_eff      = (area && !fl_eff) ? $signed(rd_data) : '0;
        pend1_eff  = line_start ? '0 : pend1;
        e_in       = (EW+1)'(h_eff) + (EW+1)'(v_eff);
    end

    // Weighted error shares; row mode sends nothing downward
    always_comb begin
        ex = PW'(err);
        m7 = ex * PW'(W_RIGHT);
        m3 = ex * PW'(W_DLEFT);
        m5 = ex * PW'(W_DOWN);
        if (area) begin
            c7 = EW'(m7 >>> W_SHIFT);
            c3 = EW'(m3 >>> W_SHIFT);
            c5 = EW'(m5 >>> W_SHIFT);
            c1 = EW'((ex * PW'(W_DRIGHT)) >>> W_SHIFT);
        end else begin
            c7 = '0;
            c3 = '0;
            c5 = '0;
            c1 = '0;
        end
    end

    // Choose between the column write and the deferred last-column write
    always_comb begin
        pix_wr   = vld && (col != '0);
        flush_wr = vld && (col == '0) && flush_pend && !sof;
        wr_en    = pix_wr | flush_wr;
        wr_addr  = pix_wr ? (col - AW'(1)) : LAST;
        wr_data  = pix_wr ? (pend0 + c3) : flush_data;
    end

    // Advance horizontal error and next-line partial sums per pixel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_reg      <= '0;
            pend0      <= '0;
            pend1      <= '0;
            first_line <= 1'b1;
            flush_pend <= 1'b0;
            flush_data <= '0;
        end else if (vld) begin
            h_reg      <= area ? c7 : err;
            pend0      <= pend1_eff + c5;
            pend1      <= last_col ? '0 : c1;
            first_line <= fl_eff;
            if (last_col) begin
                flush_pend <= 1'b1;
                flush_data <= pend1_eff + c5;
            end else if (col == '0) begin
                flush_pend <= 1'b0;
            end
        end
    end

    AST_LINE_START_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        vld && line_start && (fl_eff || !area) |-> e_in == '0)
        else $error("line start carried error");  // R6 R7

    AST_EDGE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        vld && last_col |=> pend1 == '0)
        else $error("share beyond right edge kept");  // R8

    AST_ROW_NO_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        vld && !area && (col != '0) |-> (wr_en && $signed(wr_data) == pend0))
        else $error("row pixel sent error downward");  // R10

endmodule

// File: rtl/errdif_quantizer.sv
// errdif_quantizer: 24-bit to 8-bit grayscale quantizer with row or area
// error diffusion. Stage A registers the pixel and issues the line-buffer
// read; stage B corrects, rounds and spreads the error; a final register
// drives the outputs (latency 2). Assumes full lines of LINE_W pixels.
module errdif_quantizer
    import errdif_pkg::*;
#(
    parameter int IN_W   = 24,
    parameter int OUT_W  = 8,
    parameter int LINE_W = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_sol,
    input  logic [IN_W-1:0]   in_pix,
    input  logic              diff_mode,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_pix
);

    localparam int FRAC_W = IN_W - OUT_W;
    localparam int EW     = FRAC_W + 2;
    localparam int AW     = (LINE_W > 1) ? $clog2(LINE_W) : 1;
    localparam logic [AW-1:0] LAST = AW'(LINE_W - 1);
    localparam int ERR_LO = -(1 << (FRAC_W - 1));
    localparam int ERR_HI = (1 << FRAC_W) - 1;

    logic                 b_valid, b_sol, b_sof, b_mode;
    logic [IN_W-1:0]      b_pix;
    logic [AW-1:0]        b_col, rd_addr;
    logic [EW-1:0]        rd_data;
    logic                 wr_en;
    logic [AW-1:0]        wr_addr;
    logic [EW-1:0]        wr_data;
    logic signed [EW:0]   e_in;
    logic [OUT_W-1:0]     q_code;
    logic signed [EW-1:0] q_err;

    // Column of the arriving pixel, used as the line-buffer read address
    always_comb begin
        if (in_sol || in_sof || (b_col == LAST)) begin
            rd_addr = '0;
        end else begin
            rd_addr = b_col + AW'(1);
        end
    end

    // Stage A: capture the pixel and its context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_valid <= 1'b0;
            b_sol   <= 1'b0;
            b_sof   <= 1'b0;
            b_mode  <= 1'b0;
            b_pix   <= '0;
            b_col   <= LAST;
        end else begin
            b_valid <= in_valid;
            if (in_valid) begin
                b_sol  <= in_sol;
                b_sof  <= in_sof;
                b_mode <= diff_mode;
                b_pix  <= in_pix;
                b_col  <= rd_addr;
            end
        end
    end

    errdif_linebuf #(.DEPTH(LINE_W), .W(EW), .AW(AW)) u_linebuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (in_valid),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    errdif_spread #(.EW(EW), .LINE_W(LINE_W), .AW(AW)) u_spread (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld     (b_valid),
        .sol     (b_sol),
        .sof     (b_sof),
        .mode    (diff_mode_e'(b_mode)),
        .col     (b_col),
        .err     (q_err),
        .rd_data (rd_data),
        .e_in    (e_in),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    errdif_quant #(.IN_W(IN_W), .OUT_W(OUT_W), .EW(EW)) u_quant (
        .pix  (b_pix),
        .e_in (e_in),
        .code (q_code),
        .err  (q_err)
    );

    // Stage B output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= b_valid;
            if (b_valid) begin
                out_pix <= q_code;
            end
        end
    end

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid)
        else $error("output missing two cycles after input");  // R1

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2))
        else $error("output without matching input");  // R1

    AST_ERR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        b_valid |-> (int'(q_err) >= ERR_LO && int'(q_err) <= ERR_HI))
        else $error("residue out of range");  // R3

    AST_ROUND_NEAR: assert property (@(posedge clk) disable iff (!rst_n)
        b_valid && (q_code != '1) |-> int'(q_err) < (1 << (FRAC_W - 1)))
        else $error("unsaturated code not nearest");  // R2

endmodule

// File: tb/errdif_quantizer_test.sv
`timescale 1ns/1ps
module errdif_quantizer_test;

    localparam int LINE_W = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sof = 1'b0;
    logic        in_sol = 1'b0;
    logic [23:0] in_pix = '0;
    logic        diff_mode = 1'b0;
    logic        out_valid;
    logic [7:0]  out_pix;

    errdif_quantizer uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_sol(in_sol), .in_pix(in_pix), .diff_mode(diff_mode),
        .out_valid(out_valid), .out_pix(out_pix)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit comparing = 1'b0;

    // behavioural model state
    int nb_prev[LINE_W];
    int nb_next[LINE_W];
    int m_h = 0;
    int m_col = 0;

    // expected-value delay line (latency 2)
    bit    cur_v = 1'b0, d1_v = 1'b0, d2_v = 1'b0;
    int    cur_d = 0, d1_d = 0, d2_d = 0;
    string cur_t = "", d1_t = "", d2_t = "";

    always @(posedge clk) begin
        d1_v <= cur_v; d2_v <= d1_v;
        d1_d <= cur_d; d2_d <= d1_d;
        d1_t <= cur_t; d2_t <= d1_t;
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (comparing) begin
            checks++;
            if (out_valid !== d2_v) begin
                fails++;
                $display("FAIL R1: out_valid=%0b expected=%0b", out_valid, d2_v);
            end else if (d2_v && (int'(out_pix) != d2_d)) begin
                fails++;
                $display("FAIL %s: out_pix=%0d expected=%0d", d2_t, out_pix, d2_d);
            end
        end
    end

    function automatic int pix_of(int kind, int x, int y);
        int v;
        case (kind)
            0: v = 32'h200000 + x * 32'h2345 + y * 32'h0F0F;
            1: v = 32'h031000 + x * 32'h07FF + y * 3;
            2: begin
                case (x % 6)
                    0: v = 0;
                    1: v = 32'hFFFFFF;
                    2: v = 32'h008000;
                    3: v = 32'h00FFFF;
                    4: v = 32'h7F7F7F;
                    default: v = 1;
                endcase
            end
            default: v = 32'h12A3C5;
        endcase
        return v & 32'hFFFFFF;
    endfunction

    // one pixel: drive inputs and compute the expected code from the requirements
    task automatic push(input int pix, input bit sol, input bit sof, input bit area, input string tag);
        int v, s, c, q, e;
        @(negedge clk);
        in_valid  = 1'b1;
        in_pix    = 24'(pix);
        in_sol    = sol;
        in_sof    = sof;
        diff_mode = area;
        if (sof) begin
            for (int i = 0; i < LINE_W; i++) begin nb_prev[i] = 0; nb_next[i] = 0; end
            m_h = 0; m_col = 0;                          // R7
        end else if (sol) begin
            for (int i = 0; i < LINE_W; i++) begin nb_prev[i] = nb_next[i]; nb_next[i] = 0; end
            m_h = 0; m_col = 0;                          // R6
        end else begin
            m_col++;
        end
        v = area ? nb_prev[m_col] : 0;                   // R4
        s = pix + m_h + v;
        c = (s < 0) ? 0 : ((s > 32'hFFFFFF) ? 32'hFFFFFF : s);
        q = (c + 32768) >>> 16;                          // R2
        if (q > 255) q = 255;
        e = c - q * 65536;                               // R3
        if (area) begin                                  // R5
            m_h = (7 * e) >>> 4;
            if (m_col > 0) nb_next[m_col-1] += (3 * e) >>> 4;   // R8
            nb_next[m_col] += (5 * e) >>> 4;
            if (m_col < LINE_W - 1) nb_next[m_col+1] += e >>> 4;
        end else begin
            m_h = e;                                     // R10: nothing downward
        end
        cur_v = 1'b1;
        cur_d = q;
        cur_t = tag;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0; in_sol = 1'b0; in_sof = 1'b0;
            cur_v = 1'b0;
        end
    endtask

    task automatic frame(input int kind, input int lines, input bit mode_first,
                         input bit mode_rest, input string tag, input int gap);
        string t;
        bit md;
        for (int y = 0; y < lines; y++) begin
            for (int x = 0; x < LINE_W; x++) begin
                md = (y == 0) ? mode_first : mode_rest;
                t  = tag;
                if (x == 0) t = {tag, " R6"};
                if (x == LINE_W - 1) t = {tag, " R8"};
                if (y == 0) t = {t, " R7"};
                push(pix_of(kind, x, y), x == 0, (x == 0) && (y == 0), md, t);
                if (gap > 0 && (x % gap) == gap - 1) idle(2);
            end
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected finish");
            report();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        checks++;                                        // R9 reset state
        if (out_valid !== 1'b0 || out_pix !== 8'd0) begin
            fails++;
            $display("FAIL R9: out_valid=%0b out_pix=%0d expected=0 0", out_valid, out_pix);
        end
        rst_n = 1'b1;
        comparing = 1'b1;
        idle(3);
        frame(0, 3, 1'b1, 1'b1, "R5", 0);               // area mode gradient, back to back
        idle(4);
        frame(1, 2, 1'b0, 1'b0, "R3 R4 R1", 37);        // row mode, gaps between pixels
        frame(2, 3, 1'b1, 1'b1, "R2 R5", 0);            // extremes, saturation and ties
        frame(3, 2, 1'b0, 1'b1, "R10", 0);              // row line then area line
        frame(0, 2, 1'b1, 1'b1, "R7 R5", 101);          // new frame with gaps
        idle(6);
        comparing = 1'b0;
        done = 1'b1;
        report();
        $finish;
    end

endmodule